// File: doc/BRIEF.md
# Quality-Ranked Timing Reference Selector

This block chooses which of several incoming timing references a slave network clock should follow. Every reference arrives with a presence flag and a 4-bit quality code, the kind carried on E1, SONET and SDH signals. A reference can only be chosen if it meets three conditions. It must be present. It must have stayed present for a programmable number of qualification ticks. Its traceable quality must be no worse than the clock's own stratum. Among the references that meet these conditions, the block keeps the one with the best quality.

A small mode machine reports one of three states:
- Free-run: no reference has been taken since reset.
- Locked: a reference is selected.
- Holdover: every usable reference has gone after a lock.

The block leaves holdover as soon as a usable reference qualifies again. It does not move off its current reference for an equal-quality alternative, because every move disturbs the phase. It emits a one-cycle pulse whenever it takes a new reference. It also reports the quality code its own output carries.

Top module: `clk_ref_picker`

## Requirements
- R1: Quality codes rank best to worst as 0001 (stratum 1), 0111 (stratum 2), 1010 (stratum 3), 1100 (SONET minimum clock), 0000 (traceability unknown), 1110 (reserved). The best-ranked eligible reference is selected.
- R2: Code 1111 (do not use) and every code not listed in R1 make a reference ineligible, so it is never selected.
- R3: A reference whose rank is worse than the rank of `own_ssm` is ineligible.
- R4: A reference becomes eligible only once `ref_ok` has been high while `qual_len` rising-edge samples of `qual_tick` occurred. A low `ref_ok` clears this count at once, and the reference is dropped at the next clock edge.
- R5: When several eligible references share the best rank, the lowest index wins.
- R6: While the selected reference stays eligible, the selection changes only when another reference has a strictly better rank.
- R7: `mode` is one-hot: bit0 means free-run, bit1 means locked, bit2 means holdover. After reset the block is in free-run with `sel_idx` = 0 until the first selection.
- R8: When no reference is eligible after a lock, the block enters holdover and `sel_idx` keeps its last value. It returns to locked at the edge after an eligible reference appears.
- R9: `switch_pulse` is high for exactly the one cycle after each edge at which a reference is newly selected, whether that is a first acquisition, a recovery or a change.
- R10: `out_ssm` equals the code of the selected reference while locked, and equals `own_ssm` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qual_tick | input | 1 | Qualification time base, sampled each edge |
| qual_len | input | CNT_W | Ticks needed before a reference is eligible |
| own_ssm | input | 4 | Quality code of this clock's own stratum |
| ref_ok | input | N_REF | Per-reference presence flag |
| ref_ssm | input | 4*N_REF | Per-reference quality codes, reference i at bits 4i+3:4i |
| sel_idx | output | IDX_W | Selected reference index |
| mode | output | 3 | One-hot mode: free-run, locked, holdover |
| switch_pulse | output | 1 | One-cycle pulse on each new selection |
| out_ssm | output | 4 | Quality code of the output timing |

## Verification
The selection state is a single registered index plus two flags. If any of them is wrong, the error reaches `sel_idx`, `mode` or `out_ssm` at the next edge, and the cycle-accurate model catches it within one cycle. A qualification counter that is wrong does not show immediately. It shows only as a lock that comes one or more ticks too early or too late, so the bench varies `qual_len` and tick density to make such slips visible. A faulty hysteresis compare shows up as an extra `switch_pulse` when an equal-quality reference qualifies, or as a pulse that is missing.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int RANK_W = 3;
  localparam logic [RANK_W-1:0] RANK_NONE = 3'd7;

  // Lower rank is better; 7 marks a code that may not be used for timing
  function automatic logic [RANK_W-1:0] ssm_rank(input logic [3:0] code);
    case (code)
      4'b0001: ssm_rank = 3'd0;
      4'b0111: ssm_rank = 3'd1;
      4'b1010: ssm_rank = 3'd2;
      4'b1100: ssm_rank = 3'd3;
      4'b0000: ssm_rank = 3'd4;
      4'b1110: ssm_rank = 3'd5;
      default: ssm_rank = RANK_NONE;
    endcase
  endfunction

  function automatic logic ssm_usable(input logic [RANK_W-1:0] r,
                                      input logic [RANK_W-1:0] own_r);
    ssm_usable = (r != RANK_NONE) && (r <= own_r);
  endfunction
endpackage

// File: rtl/clksel_qualifier.sv
module clksel_qualifier #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] len,
  input  logic             ok,
  output logic             qualified
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (!ok)                     cnt <= '0;
    else if (tick && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  assign qualified = ok && (cnt >= len);
endmodule

// File: rtl/clksel_best.sv
module clksel_best #(
  parameter int N_REF = 4,
  localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic [N_REF-1:0]                         elig,
  input  logic [N_REF-1:0][clksel_pkg::RANK_W-1:0] rank,
  output logic                                     any_elig,
  output logic [IDX_W-1:0]                         best_idx,
  output logic [clksel_pkg::RANK_W-1:0]            best_rank
);
  always_comb begin
    any_elig  = 1'b0;
    best_idx  = '0;
    best_rank = clksel_pkg::RANK_NONE;
    for (int i = 0; i < N_REF; i++) begin
      if (elig[i] && (!any_elig || rank[i] < best_rank)) begin
        any_elig  = 1'b1;
        best_idx  = IDX_W'(i);
        best_rank = rank[i];
      end
    end
  end
endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm #(
  parameter int N_REF = 4,
  localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [N_REF-1:0]                         elig,
  input  logic [N_REF-1:0][clksel_pkg::RANK_W-1:0] rank,
  input  logic                                     any_elig,
  input  logic [IDX_W-1:0]                         best_idx,
  input  logic [clksel_pkg::RANK_W-1:0]            best_rank,
  output logic [IDX_W-1:0]                         cur_idx,
  output logic                                     have_ref,
  output logic                                     ever_locked,
  output logic                                     take_new,
  output logic                                     pulse_q
);
  logic cur_ok, better;

  assign cur_ok   = have_ref && elig[cur_idx];
  assign better   = any_elig && (best_rank < rank[cur_idx]);
  assign take_new = cur_ok ? better : any_elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx     <= '0;
      have_ref    <= 1'b0;
      ever_locked <= 1'b0;
      pulse_q     <= 1'b0;
    end else begin
      pulse_q  <= take_new;
      have_ref <= cur_ok || any_elig;
      if (take_new) begin
        cur_idx     <= best_idx;
        ever_locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_ref_picker.sv
module clk_ref_picker #(
  parameter int N_REF = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qual_tick,
  input  logic [CNT_W-1:0]   qual_len,
  input  logic [3:0]         own_ssm,
  input  logic [N_REF-1:0]   ref_ok,
  input  logic [4*N_REF-1:0] ref_ssm,
  output logic [IDX_W-1:0]   sel_idx,
  output logic [2:0]         mode,
  output logic               switch_pulse,
  output logic [3:0]         out_ssm
);
  import clksel_pkg::*;

  logic [N_REF-1:0]             qualified;
  logic [N_REF-1:0]             elig;
  logic [N_REF-1:0][RANK_W-1:0] rank;
  logic [RANK_W-1:0]            own_rank;
  logic                         any_elig;
  logic [IDX_W-1:0]             best_idx;
  logic [RANK_W-1:0]            best_rank;
  logic                         have_ref, ever_locked, take_new;

  assign own_rank = ssm_rank(own_ssm);

  for (genvar g = 0; g < N_REF; g++) begin : g_ref
    clksel_qualifier #(.CNT_W(CNT_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .tick(qual_tick), .len(qual_len),
      .ok(ref_ok[g]), .qualified(qualified[g])
    );
    assign rank[g] = ssm_rank(ref_ssm[4*g +: 4]);
    assign elig[g] = qualified[g] && ssm_usable(rank[g], own_rank);
  end

  clksel_best #(.N_REF(N_REF)) u_best (
    .elig(elig), .rank(rank), .any_elig(any_elig),
    .best_idx(best_idx), .best_rank(best_rank)
  );

  clksel_fsm #(.N_REF(N_REF)) u_fsm (
    .clk(clk), .rst_n(rst_n), .elig(elig), .rank(rank),
    .any_elig(any_elig), .best_idx(best_idx), .best_rank(best_rank),
    .cur_idx(sel_idx), .have_ref(have_ref), .ever_locked(ever_locked),
    .take_new(take_new), .pulse_q(switch_pulse)
  );

  assign mode    = have_ref ? 3'b010 : (ever_locked ? 3'b100 : 3'b001);
  assign out_ssm = have_ref ? ref_ssm[4*sel_idx +: 4] : own_ssm;
endmodule

// File: rtl/clk_ref_picker_chk.sv
module clk_ref_picker_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] sel_idx,
  input logic [2:0]       mode,
  input logic             switch_pulse,
  input logic [3:0]       out_ssm,
  input logic [3:0]       own_ssm,
  input logic             any_elig
);
  p_mode_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode) == 1);

  p_hold_never_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode[2]) |-> !mode[0]);

  p_pulse_when_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> mode[1]);

  p_pulse_had_candidate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> $past(any_elig));

  p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && $past(mode[1]) && !switch_pulse) |-> $stable(sel_idx));

  p_own_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |-> out_ssm == own_ssm);
endmodule

bind clk_ref_picker clk_ref_picker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .mode(mode),
  .switch_pulse(switch_pulse), .out_ssm(out_ssm), .own_ssm(own_ssm),
  .any_elig(any_elig)
);

// File: tb/clk_ref_picker_test.sv
module clk_ref_picker_test;
  localparam int N = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          qual_tick = 1'b0;
  logic [CW-1:0] qual_len = 8'd2;
  logic [3:0]    own_ssm = 4'b1010;
  logic [N-1:0]  ref_ok = '0;
  logic [4*N-1:0] ref_ssm = '1;
  logic [1:0]    sel_idx;
  logic [2:0]    mode;
  logic          switch_pulse;
  logic [3:0]    out_ssm;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  clk_ref_picker #(.N_REF(N), .CNT_W(CW)) uut (.*);

  always #10 clk = ~clk;

  // quality order, best first
  function automatic int q_order(input logic [3:0] c);
    logic [3:0] ladder [6] = '{4'h1, 4'h7, 4'hA, 4'hC, 4'h0, 4'hE};
    q_order = 99;
    foreach (ladder[k]) if (ladder[k] == c && q_order == 99) q_order = k;
  endfunction

  // bench model
  int m_cnt [N];
  int m_cur = 0;
  bit m_have = 0, m_ever = 0, m_sw = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_cur = 0; m_have = 0; m_ever = 0; m_sw = 0;
    end else begin
      bit el [N];
      int bi, br;
      bit any;
      any = 0; bi = 0; br = 99;
      for (int i = 0; i < N; i++) begin
        int q;
        q = q_order(ref_ssm[4*i +: 4]);
        el[i] = ref_ok[i] && m_cnt[i] >= int'(qual_len) && q != 99
                && q <= q_order(own_ssm);
        if (el[i] && q < br) begin any = 1; bi = i; br = q; end
      end
      m_sw = 0;
      if (m_have && el[m_cur]) begin
        if (any && br < q_order(ref_ssm[4*m_cur +: 4])) begin m_cur = bi; m_sw = 1; end
      end else if (any) begin
        m_cur = bi; m_have = 1; m_ever = 1; m_sw = 1;
      end else m_have = 0;
      for (int i = 0; i < N; i++)
        if (!ref_ok[i]) m_cnt[i] = 0;
        else if (qual_tick && m_cnt[i] < 255) m_cnt[i]++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R7/R8 mode", mode, m_have ? 2 : (m_ever ? 4 : 1));
    check("R1/R5/R6 sel_idx", sel_idx, m_cur);
    check("R9 switch_pulse", switch_pulse, m_sw);
    check("R10 out_ssm", out_ssm, m_have ? int'(ref_ssm[4*m_cur +: 4]) : int'(own_ssm));
  endtask

  task automatic set_ref(input int i, input bit ok, input logic [3:0] c);
    ref_ok[i] = ok;
    ref_ssm[4*i +: 4] = c;
  endtask

  initial begin
    logic [3:0] codes [8] = '{4'h1, 4'h7, 4'hA, 4'hC, 4'h0, 4'hE, 4'hF, 4'h3};
    int seed;
    seed = $urandom(1234);
    qual_tick = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R7 reset mode", mode, 1);
    check("R7 reset sel", sel_idx, 0);
    check("R10 reset code", out_ssm, 4'hA);
    step();
    // directed: S3, S2, do-not-use, unknown
    set_ref(0, 1, 4'hA); set_ref(1, 1, 4'h7); set_ref(2, 1, 4'hF); set_ref(3, 1, 4'h0);
    step(); step();
    check("R4 not yet qualified", mode, 1);
    step();
    check("R1 best rank chosen", sel_idx, 1);
    check("R9 pulse on acquire", switch_pulse, 1);
    step();
    check("R9 pulse one cycle", switch_pulse, 0);
    ref_ok[1] = 0;
    step();
    check("R4 lost ref dropped at once", sel_idx, 0);
    ref_ok[0] = 0;
    step();
    check("R2 R3 holdover despite dnu and unknown refs", mode, 4);
    check("R8 sel kept in holdover", sel_idx, 0);
    check("R10 own code in holdover", out_ssm, 4'hA);
    ref_ok[0] = 1;
    repeat (3) step();
    check("R8 relock", mode, 2);
    set_ref(1, 1, 4'hA);
    repeat (4) step();
    check("R6 equal rank keeps current", sel_idx, 0);
    ref_ssm[3:0] = 4'hC;
    step();
    check("R3 worse than own dropped", sel_idx, 1);
    ref_ssm[3:0] = 4'hA;
    repeat (2) step();
    check("R6 no return for equal", sel_idx, 1);
    ref_ok = '0;
    step();
    set_ref(0, 1, 4'h7); set_ref(1, 1, 4'h7); set_ref(2, 1, 4'h3);
    repeat (3) step();
    check("R5 tie lower index", sel_idx, 0);
    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      own_ssm = codes[ph % 4];
      qual_len = CW'($urandom_range(0, 3));
      for (int c = 0; c < 1500; c++) begin
        qual_tick = ($urandom_range(0, 1) == 1);
        for (int i = 0; i < N; i++) begin
          if ($urandom_range(0, 19) == 0) ref_ok[i] = ~ref_ok[i];
          if ($urandom_range(0, 39) == 0) ref_ssm[4*i +: 4] = codes[$urandom_range(0, 7)];
        end
        step();
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule